// File: doc/BRIEF.md
# Memory Access Watch Unit

The watch unit sits beside a simple bus and observes each access without taking part in it. It never stalls, blocks or answers a transfer. For every access it checks whether the address falls inside any of its configured windows. There are `NUSR` user windows, each bounded by a programmable low and high address, and `NPER` fixed peripheral windows. Each peripheral window is cut into 32 equal subregions, and an include mask picks which of them are watched.

Each window has its own read event and its own write event, and each event is armed by its own watch-enable bit. Pending events drive two level outputs, `irq` and `nmi`, and each output has its own enable mask. Each peripheral window also keeps sticky per-subregion read and write hit bitmaps. Software uses these to find which subregion was touched. Configuration goes through a single-cycle word register port: writes take effect at the clock edge, and read data is combinational from `cfg_addr`.

Top module: `mem_watch_unit`

## Requirements
- R1: A user window `i` matches when its low address <= the access address <= its high address, with both ends included. A valid access with a matching address and an armed direction sets the event on the clock edge that samples the access. Window `i` has its low bound at register word 0x08+2i and its high bound at 0x09+2i.
- R2: A user window whose high address is below its low address never matches any address.
- R3: Peripheral window `p` spans 32 subregions of 2^`SUB_LOG2` bytes, starting at base `p` of `PER_BASES`. The subregion index is address bits [`SUB_LOG2`+4:`SUB_LOG2`]. Only subregions whose bit is set in the include mask (word 0x20+p) are watched.
- R4: Event bit positions are as follows. User window `i` uses bit 2i for writes and bit 2i+1 for reads. Peripheral window `p` uses bit 2(`NUSR`+p) for writes and 2(`NUSR`+p)+1 for reads. An access sets an event only when the watch-enable bit at the same position is 1, so reads and writes are armed independently.
- R5: The watch-enable mask is set by writing ones to word 0x00 and cleared by writing ones to word 0x01. Zero bits leave the mask unchanged. Reading word 0x00 returns the mask.
- R6: Event `k` is read at word 0x10+k, and bit 0 reads 1 while the event is pending. Writing a value with bit 0 = 0 clears the event. Writing bit 0 = 1 has no effect.
- R7: `irq` is high while any pending event has its bit set in the interrupt mask. The interrupt mask is set through word 0x02, cleared through word 0x03 and read at 0x02. `irq` stays high until the event or its mask bit is cleared.
- R8: `nmi` follows the same rule with a separate mask, set through word 0x04, cleared through word 0x05 and read at 0x04. That mask is independent of the interrupt mask.
- R9: Each peripheral window keeps a sticky write-hit bitmap (word 0x22+2p) and a sticky read-hit bitmap (word 0x23+2p). A bit is set by an armed hit on that subregion. Writing a mask to a bitmap clears the bits that are 1 in the mask and no others.
- R10: When a hit and a software clear of the same event or bitmap bit fall in the same cycle, the bit ends up set.
- R11: After reset every mask, bound, include mask, event and bitmap is 0, and `irq` and `nmi` are low.
- R12: A cycle with `bus_valid` low sets no event and no bitmap bit, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | An access is on the bus this cycle |
| bus_write | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | AW | Access address |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Maskable interrupt level |
| nmi | output | 1 | Non-maskable interrupt level |

## Verification
Each result has a fixed due time:
- A bus access sampled on edge t shows in the events, bitmaps, `irq` and `nmi` right after edge t.
- A register write sampled on edge t is visible after edge t.
- Register reads are due in the same cycle as `cfg_addr`.

The bench changes inputs only on the falling edge and samples one time step after a falling edge. Every check therefore falls half a cycle after the edge that made the result. The simultaneous hit-and-clear cases drive both strobes on the same falling edge, so a single rising edge sees both.

// File: rtl/mwu_pkg.sv
// Package: register word map and shared widths of the memory access watch unit.
// Assumes at most four user windows, so the range words stay below 0x10.
package mwu_pkg;
    localparam int CFG_AW = 6;
    localparam int DW     = 32;
    localparam int NSUB   = 32;

    localparam logic [CFG_AW-1:0] A_WEN_SET  = 6'h00;
    localparam logic [CFG_AW-1:0] A_WEN_CLR  = 6'h01;
    localparam logic [CFG_AW-1:0] A_IEN_SET  = 6'h02;
    localparam logic [CFG_AW-1:0] A_IEN_CLR  = 6'h03;
    localparam logic [CFG_AW-1:0] A_NEN_SET  = 6'h04;
    localparam logic [CFG_AW-1:0] A_NEN_CLR  = 6'h05;
    localparam logic [CFG_AW-1:0] A_RANGE    = 6'h08;
    localparam logic [CFG_AW-1:0] A_EVT      = 6'h10;
    localparam logic [CFG_AW-1:0] A_SUBINC   = 6'h20;
    localparam logic [CFG_AW-1:0] A_MAP      = 6'h22;
endpackage

// File: rtl/mwu_user_cmp.sv
// Module: inclusive address compare for one user window.
// Assumes lo/hi are stable register outputs; a window with hi < lo never hits.
module mwu_user_cmp #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          hit
);
    // Window match with both bounds included.
    always_comb hit = (addr >= lo) && (addr <= hi);

    // R2
    inverted_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hi >= lo));
endmodule

// File: rtl/mwu_periph_track.sv
// Module: one peripheral window of 32 subregions with sticky read/write hit maps.
// Assumes BASE is aligned to the window size (2^(SUB_LOG2+5) bytes).
module mwu_periph_track #(
    parameter int              AW       = 32,
    parameter int              SUB_LOG2 = 8,
    parameter logic [AW-1:0]   BASE     = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic                     acc_write,
    input  logic [AW-1:SUB_LOG2]     addr_hi,
    input  logic [mwu_pkg::NSUB-1:0] incl,
    input  logic                     watch_w,
    input  logic                     watch_r,
    input  logic                     clr_w_we,
    input  logic                     clr_r_we,
    input  logic [mwu_pkg::NSUB-1:0] clr_mask,
    output logic                     hit_w,
    output logic                     hit_r,
    output logic [mwu_pkg::NSUB-1:0] wmap,
    output logic [mwu_pkg::NSUB-1:0] rmap
);
    localparam int TOP_LSB = SUB_LOG2 + $clog2(mwu_pkg::NSUB);

    logic                     in_win;
    logic [TOP_LSB-SUB_LOG2-1:0] idx;
    logic                     sel;
    logic [mwu_pkg::NSUB-1:0] onehot;

    // Window decode, subregion index and include check.
    always_comb begin
        in_win = (addr_hi[AW-1:TOP_LSB] == BASE[AW-1:TOP_LSB]);
        idx    = addr_hi[TOP_LSB-1:SUB_LOG2];
        sel    = acc_valid && in_win && incl[idx];
        onehot = mwu_pkg::NSUB'(1) << idx;
        hit_w  = sel && acc_write && watch_w;
        hit_r  = sel && !acc_write && watch_r;
    end

    // Sticky maps: clear-by-mask first, a same-cycle hit re-sets its bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wmap <= '0;
            rmap <= '0;
        end else begin
            wmap <= (wmap & ~(clr_w_we ? clr_mask : '0)) | (hit_w ? onehot : '0);
            rmap <= (rmap & ~(clr_r_we ? clr_mask : '0)) | (hit_r ? onehot : '0);
        end
    end

    // R9
    wmap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wmap & ~$past(wmap))) |-> $past(acc_valid && acc_write));
    // R10
    rmap_hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_r && clr_r_we) |=> (rmap & $past(onehot)) != '0);
endmodule

// File: rtl/mwu_event_bank.sv
// Module: pending event flags and the two masked interrupt levels.
// Assumes set_vec is already gated by the watch enables.
module mwu_event_bank #(
    parameter int NEV = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set_vec,
    input  logic [NEV-1:0] clr_vec,
    input  logic [NEV-1:0] ien,
    input  logic [NEV-1:0] nen,
    output logic [NEV-1:0] evt,
    output logic           irq,
    output logic           nmi
);
    // Event flags: a new hit overrides a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= '0;
        else        evt <= (evt & ~clr_vec) | set_vec;
    end

    // Interrupt levels from pending events under each mask.
    always_comb begin
        irq = |(evt & ien);
        nmi = |(evt & nen);
    end

    // R1 R10
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((evt & $past(set_vec)) == $past(set_vec)));
    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && clr_vec == '0) |=> (irq || ien != $past(ien)));
    // R8
    nmi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && clr_vec == '0) |=> (nmi || nen != $past(nen)));
endmodule

// File: rtl/mem_watch_unit.sv
// Module: memory access watch unit top; holds the configuration registers,
// the register read path and the event routing.
// Assumes NUSR <= 4 and AW <= 32; observes the bus only.
module mem_watch_unit #(
    parameter int                  AW        = 32,
    parameter int                  NUSR      = 4,
    parameter int                  NPER      = 2,
    parameter int                  SUB_LOG2  = 8,
    parameter logic [NPER*AW-1:0]  PER_BASES = {32'h4000_2000, 32'h4000_0000}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [AW-1:0]               bus_addr,
    input  logic                        cfg_we,
    input  logic [mwu_pkg::CFG_AW-1:0]  cfg_addr,
    input  logic [mwu_pkg::DW-1:0]      cfg_wdata,
    output logic [mwu_pkg::DW-1:0]      cfg_rdata,
    output logic                        irq,
    output logic                        nmi
);
    import mwu_pkg::*;

    localparam int NEV = 2 * (NUSR + NPER);

    logic [NEV-1:0]  wen, ien, nen, set_vec, clr_vec, evt;
    logic [AW-1:0]   lo   [NUSR];
    logic [AW-1:0]   hi   [NUSR];
    logic [NUSR-1:0] uhit;
    logic [NSUB-1:0] incl [NPER];
    logic [NSUB-1:0] wmap [NPER];
    logic [NSUB-1:0] rmap [NPER];
    logic [NPER-1:0] phit_w, phit_r, clr_w_we, clr_r_we;

    // User windows: compare and route to events 2i (write), 2i+1 (read).
    for (genvar i = 0; i < NUSR; i++) begin : g_usr
        mwu_user_cmp #(.AW(AW)) u_cmp (
            .clk(clk), .rst_n(rst_n), .addr(bus_addr),
            .lo(lo[i]), .hi(hi[i]), .hit(uhit[i]));
        assign set_vec[2*i]   = bus_valid && uhit[i] &&  bus_write && wen[2*i];
        assign set_vec[2*i+1] = bus_valid && uhit[i] && !bus_write && wen[2*i+1];
    end

    // Peripheral windows: subregion tracking and events 2(NUSR+p), +1.
    for (genvar p = 0; p < NPER; p++) begin : g_per
        localparam int EW = 2 * (NUSR + p);
        assign clr_w_we[p] = cfg_we && cfg_addr == A_MAP + CFG_AW'(2*p);
        assign clr_r_we[p] = cfg_we && cfg_addr == A_MAP + CFG_AW'(2*p+1);
        mwu_periph_track #(.AW(AW), .SUB_LOG2(SUB_LOG2),
                           .BASE(PER_BASES[p*AW +: AW])) u_trk (
            .clk(clk), .rst_n(rst_n), .acc_valid(bus_valid), .acc_write(bus_write),
            .addr_hi(bus_addr[AW-1:SUB_LOG2]), .incl(incl[p]),
            .watch_w(wen[EW]), .watch_r(wen[EW+1]),
            .clr_w_we(clr_w_we[p]), .clr_r_we(clr_r_we[p]), .clr_mask(cfg_wdata),
            .hit_w(phit_w[p]), .hit_r(phit_r[p]), .wmap(wmap[p]), .rmap(rmap[p]));
        assign set_vec[EW]   = phit_w[p];
        assign set_vec[EW+1] = phit_r[p];
    end

    // Event clears: writing bit 0 = 0 to an event word.
    for (genvar k = 0; k < NEV; k++) begin : g_clr
        assign clr_vec[k] = cfg_we && !cfg_wdata[0] && cfg_addr == A_EVT + CFG_AW'(k);
    end

    mwu_event_bank #(.NEV(NEV)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .ien(ien), .nen(nen), .evt(evt), .irq(irq), .nmi(nmi));

    // Configuration register writes: set/clear masks, bounds, include masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen <= '0;
            ien <= '0;
            nen <= '0;
            for (int i = 0; i < NUSR; i++) begin
                lo[i] <= '0;
                hi[i] <= '0;
            end
            for (int p = 0; p < NPER; p++) incl[p] <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_WEN_SET: wen <= wen |  cfg_wdata[NEV-1:0];
                A_WEN_CLR: wen <= wen & ~cfg_wdata[NEV-1:0];
                A_IEN_SET: ien <= ien |  cfg_wdata[NEV-1:0];
                A_IEN_CLR: ien <= ien & ~cfg_wdata[NEV-1:0];
                A_NEN_SET: nen <= nen |  cfg_wdata[NEV-1:0];
                A_NEN_CLR: nen <= nen & ~cfg_wdata[NEV-1:0];
                default: ;
            endcase
            for (int i = 0; i < NUSR; i++) begin
                if (cfg_addr == A_RANGE + CFG_AW'(2*i))   lo[i] <= cfg_wdata[AW-1:0];
                if (cfg_addr == A_RANGE + CFG_AW'(2*i+1)) hi[i] <= cfg_wdata[AW-1:0];
            end
            for (int p = 0; p < NPER; p++) begin
                if (cfg_addr == A_SUBINC + CFG_AW'(p)) incl[p] <= cfg_wdata;
            end
        end
    end

    // Register read path, combinational on cfg_addr.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            A_WEN_SET, A_WEN_CLR: cfg_rdata[NEV-1:0] = wen;
            A_IEN_SET, A_IEN_CLR: cfg_rdata[NEV-1:0] = ien;
            A_NEN_SET, A_NEN_CLR: cfg_rdata[NEV-1:0] = nen;
            default: ;
        endcase
        for (int i = 0; i < NUSR; i++) begin
            if (cfg_addr == A_RANGE + CFG_AW'(2*i))   cfg_rdata = DW'(lo[i]);
            if (cfg_addr == A_RANGE + CFG_AW'(2*i+1)) cfg_rdata = DW'(hi[i]);
        end
        for (int k = 0; k < NEV; k++) begin
            if (cfg_addr == A_EVT + CFG_AW'(k)) cfg_rdata = DW'(evt[k]);
        end
        for (int p = 0; p < NPER; p++) begin
            if (cfg_addr == A_SUBINC + CFG_AW'(p))  cfg_rdata = incl[p];
            if (cfg_addr == A_MAP + CFG_AW'(2*p))   cfg_rdata = wmap[p];
            if (cfg_addr == A_MAP + CFG_AW'(2*p+1)) cfg_rdata = rmap[p];
        end
    end

    // R12
    no_spurious_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & ~$past(evt))) |-> $past(bus_valid));
    // R4
    armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & ~$past(evt))) |-> (|($past(wen) & evt & ~$past(evt))));
endmodule

// File: tb/mem_watch_unit_bench.sv
// Bench: directed scenarios, one task each, every task checks its own results.
module mem_watch_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq, nmi;
    int          n_chk = 0, n_err = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    mem_watch_unit u_mem_watch_unit (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq), .nmi(nmi));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic bus_acc(input logic [31:0] a, input logic w, input logic v = 1'b1);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        #1;
    endtask

    task automatic clear_all_events();
        for (int k = 0; k < 12; k++) cfg_wr(6'h10 + 6'(k), 32'h0);
    endtask

    task automatic t_reset();
        cfg_rd(6'h00, rd); chk("R11 watch mask", rd, 0);
        cfg_rd(6'h10, rd); chk("R11 event0", rd, 0);
        cfg_rd(6'h22, rd); chk("R11 wmap0", rd, 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 nmi", 32'(nmi), 0);
    endtask

    task automatic t_user_windows();
        cfg_wr(6'h08, 32'h1000); cfg_wr(6'h09, 32'h10FF);
        cfg_wr(6'h0A, 32'h2000); cfg_wr(6'h0B, 32'h2FFF);
        cfg_wr(6'h00, 32'h0000_0007);
        cfg_rd(6'h00, rd); chk("R5 set reads mask", rd, 32'h7);
        bus_acc(32'h1000, 1'b1);
        cfg_rd(6'h10, rd); chk("R1 low bound write hit", rd, 1);
        bus_acc(32'h10FF, 1'b0);
        cfg_rd(6'h11, rd); chk("R1 high bound read hit", rd, 1);
        cfg_wr(6'h11, 32'h0);
        bus_acc(32'h1100, 1'b0);
        cfg_rd(6'h11, rd); chk("R1 one past high bound", rd, 0);
        bus_acc(32'h2800, 1'b0);
        cfg_rd(6'h13, rd); chk("R4 read not armed", rd, 0);
        bus_acc(32'h2800, 1'b1);
        cfg_rd(6'h12, rd); chk("R4 write armed", rd, 1);
    endtask

    task automatic t_inverted();
        cfg_wr(6'h0C, 32'h5000); cfg_wr(6'h0D, 32'h4FFF);
        cfg_wr(6'h00, 32'h0000_0030);
        bus_acc(32'h5000, 1'b1);
        bus_acc(32'h4FFF, 1'b0);
        cfg_rd(6'h14, rd); chk("R2 inverted write", rd, 0);
        cfg_rd(6'h15, rd); chk("R2 inverted read", rd, 0);
    endtask

    task automatic t_event_clear();
        cfg_wr(6'h10, 32'h1);
        cfg_rd(6'h10, rd); chk("R6 write one ignored", rd, 1);
        cfg_wr(6'h10, 32'h0);
        cfg_rd(6'h10, rd); chk("R6 write zero clears", rd, 0);
    endtask

    task automatic t_irq_nmi();
        clear_all_events();
        cfg_wr(6'h02, 32'h1);
        cfg_wr(6'h04, 32'h4);
        cfg_rd(6'h02, rd); chk("R7 irq mask read", rd, 32'h1);
        cfg_rd(6'h04, rd); chk("R8 nmi mask read", rd, 32'h4);
        bus_acc(32'h1010, 1'b1);
        chk("R7 irq raised", 32'(irq), 1);
        chk("R8 nmi not raised", 32'(nmi), 0);
        repeat (3) @(negedge clk);
        #1 chk("R7 irq holds", 32'(irq), 1);
        cfg_wr(6'h03, 32'h1);
        #1 chk("R7 irq mask clear", 32'(irq), 0);
        bus_acc(32'h2004, 1'b1);
        chk("R8 nmi raised", 32'(nmi), 1);
        chk("R7 irq stays low", 32'(irq), 0);
        cfg_wr(6'h12, 32'h0);
        #1 chk("R8 nmi drops on clear", 32'(nmi), 0);
        cfg_wr(6'h05, 32'h4);
    endtask

    task automatic t_watch_clear();
        cfg_wr(6'h01, 32'h1);
        cfg_rd(6'h00, rd); chk("R5 clear only bit0", rd, 32'h36);
        clear_all_events();
        bus_acc(32'h1000, 1'b1);
        cfg_rd(6'h10, rd); chk("R5 disarmed no event", rd, 0);
    endtask

    task automatic t_periph();
        cfg_wr(6'h00, 32'h0000_0F00);
        cfg_wr(6'h20, 32'h0000_0005);
        cfg_wr(6'h21, 32'h8000_0000);
        bus_acc(32'h4000_0204, 1'b1);
        cfg_rd(6'h22, rd); chk("R3 sub2 write map", rd, 32'h4);
        cfg_rd(6'h18, rd); chk("R3 periph0 write event", rd, 1);
        bus_acc(32'h4000_0100, 1'b1);
        cfg_rd(6'h22, rd); chk("R3 excluded sub1", rd, 32'h4);
        bus_acc(32'h4000_0010, 1'b0);
        cfg_rd(6'h23, rd); chk("R3 sub0 read map", rd, 32'h1);
        cfg_rd(6'h19, rd); chk("R4 periph0 read event", rd, 1);
        bus_acc(32'h4000_3F00, 1'b1);
        cfg_rd(6'h24, rd); chk("R3 periph1 sub31", rd, 32'h8000_0000);
        cfg_rd(6'h1A, rd); chk("R4 periph1 write event", rd, 1);
        bus_acc(32'h4000_0204, 1'b1, 1'b0);
        cfg_rd(6'h23, rd); chk("R12 idle leaves rmap", rd, 32'h1);
        cfg_wr(6'h22, 32'h4);
        cfg_rd(6'h22, rd); chk("R9 clear by ones", rd, 0);
        cfg_wr(6'h23, 32'h2);
        cfg_rd(6'h23, rd); chk("R9 clear other bit kept", rd, 32'h1);
    endtask

    task automatic t_collision();
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'h22; cfg_wdata = 32'h4;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 32'h4000_0200;
        @(negedge clk);
        cfg_we = 1'b0; bus_valid = 1'b0;
        cfg_rd(6'h22, rd); chk("R10 map hit wins", rd, 32'h4);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'h18; cfg_wdata = 32'h0;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 32'h4000_0200;
        @(negedge clk);
        cfg_we = 1'b0; bus_valid = 1'b0;
        cfg_rd(6'h18, rd); chk("R10 event hit wins", rd, 1);
    endtask

    task automatic t_idle();
        clear_all_events();
        bus_acc(32'h1000, 1'b1, 1'b0);
        bus_acc(32'h2000, 1'b1, 1'b0);
        cfg_rd(6'h12, rd); chk("R12 idle no event", rd, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_user_windows();
        t_inverted();
        t_event_clear();
        t_irq_nmi();
        t_watch_clear();
        t_periph();
        t_collision();
        t_idle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule